// File: doc/BRIEF.md
# Standby Wake-Up Clock Controller

This block governs the way out of a low-power standby state in which the main oscillator is halted. While the chip runs, software programs a small control register with the wake polarity of the non-maskable interrupt pin and a 3-bit stabilization code. A one-cycle request from the surrounding power sequencer then parks the block in standby. In standby the oscillator enable, the watchdog clock enable and the chip clock enable are all low.

A qualifying edge on the interrupt pin turns the oscillator back on. At first its clock is released only to an internal stabilization counter. The counter's overflow is taken as proof that the oscillator has settled. Only then is the clock opened to the whole chip, and a one-cycle exception request is raised for the interrupt handler. An asynchronous power-on reset or a synchronous manual reset returns the block to normal running at once, whatever the count.

The `clk` input models the oscillator output as seen by this logic. The block's clock-enable outputs drive the gating cells elsewhere.

Top module: `standby_wake_ctrl`

## Requirements
- R1: After power-on reset (`rst_n` low) the block is running: `osc_en`=1, `wdt_clk_en`=1, `chip_clk_en`=1, `nmi_exc_req`=0. The control register holds falling-edge wake and stabilization code 0.
- R2: A `standby_req` pulse while running drives `osc_en`, `wdt_clk_en` and `chip_clk_en` low from the next clock edge. They stay low until a wake event.
- R3: When `cfg_we` is high while running, the control register loads `cfg_wdata`: bit 3 selects rising-edge wake (1) or falling-edge wake (0), and bits 2:0 are the stabilization code k. A write in any other state is ignored.
- R4: The interrupt pin passes through a two-flop synchronizer before edge detection. In standby, only an edge of the programmed polarity wakes the block; an edge of the opposite polarity leaves all clock enables low.
- R5: After a valid wake edge, `osc_en` and `wdt_clk_en` are 1 and `chip_clk_en` is 0 for exactly 2^(k+1) clock cycles (k = 0..7).
- R6: When stabilization ends, there is exactly one cycle with `chip_clk_en`=1 and `nmi_exc_req`=1. The block then runs with `nmi_exc_req`=0.
- R7: Further interrupt-pin edges during stabilization neither restart nor extend the count.
- R8: `man_rst_n` low at a clock edge returns the block to running from any state without an exception request. It takes priority over every other transition.
- R9: `rst_n` low returns the block to running asynchronously from any state, including standby, and restores the register defaults of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock seen by the controller |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| man_rst_n | input | 1 | Synchronous manual reset, active low |
| standby_req | input | 1 | One-cycle request to enter standby |
| nmi_pin | input | 1 | Raw non-maskable interrupt pin |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 4 | Bit 3 wake polarity (1 rising), bits 2:0 stabilization code |
| osc_en | output | 1 | Enable for the analog oscillator |
| wdt_clk_en | output | 1 | Clock enable for the stabilization watchdog |
| chip_clk_en | output | 1 | Clock enable for the rest of the chip |
| nmi_exc_req | output | 1 | One-cycle request for interrupt exception processing |

## Verification
The bench builds the block with its default parameters: a 3-bit stabilization code, a two-stage synchronizer and an 8-bit counter. This makes every period from 2 up to 256 cycles reachable, and the bench sweeps codes 0 and 7 as well as random codes in between. The longest period leaves enough room to toggle the pin twice in mid-count and to land a manual reset deep inside stabilization.

// File: rtl/swc_pkg.sv
package swc_pkg;

    localparam int CODE_W = 3;

    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_STANDBY   = 2'd1,
        ST_STABILIZE = 2'd2,
        ST_WAKE      = 2'd3
    } swc_state_e;

    typedef struct packed {
        logic              wake_rise;
        logic [CODE_W-1:0] code;
    } swc_cfg_t;

endpackage

// File: rtl/swc_pin_sync.sv
module swc_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic sel_rise,
    output logic wake_edge
);
    // stage STAGES-1 is the synchronized level, stage STAGES its previous value
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = pin;
    end

    for (genvar g = 1; g <= STAGES; g++) begin : g_stage
        always_comb chain_d[g] = chain_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    logic lvl_now, lvl_old;
    assign lvl_now   = chain_q[STAGES-1];
    assign lvl_old   = chain_q[STAGES];
    assign wake_edge = sel_rise ? (lvl_now & ~lvl_old) : (~lvl_now & lvl_old);

    // R4: a reported edge always follows a level that differed one cycle earlier
    assert_edge_from_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wake_edge |-> (lvl_now != lvl_old));

endmodule

// File: rtl/swc_cfg_reg.sv
module swc_cfg_reg
    import swc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  logic     wr_allow,
    input  swc_cfg_t wr_data,
    output swc_cfg_t cfg
);
    swc_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && wr_allow) cfg_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    assert_cfg_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_allow |=> $stable(cfg_q));

endmodule

// File: rtl/swc_stab_wdt.sv
module swc_stab_wdt #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              ovf
);
    localparam int CNT_W = 1 << CODE_W;

    logic [CNT_W-1:0] lim;
    logic [CNT_W-1:0] cnt_d, cnt_q;

    // terminal count 2^(code+1)-1: bits 0..code set
    for (genvar i = 0; i < CNT_W; i++) begin : g_lim
        assign lim[i] = (code >= CODE_W'(i));
    end

    assign ovf = run && (cnt_q == lim);

    always_comb begin
        cnt_d = cnt_q;
        if (!run || ovf) cnt_d = '0;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R7: while counting, each cycle advances by one; nothing restarts it
    assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ovf) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

    // R5: counting always starts from zero
    assert_start_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |=> (cnt_q == '0));

endmodule

// File: rtl/standby_wake_ctrl.sv
module standby_wake_ctrl
    import swc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       man_rst_n,
    input  logic       standby_req,
    input  logic       nmi_pin,
    input  logic       cfg_we,
    input  logic [3:0] cfg_wdata,
    output logic       osc_en,
    output logic       wdt_clk_en,
    output logic       chip_clk_en,
    output logic       nmi_exc_req
);
    typedef struct packed {
        swc_state_e st;
    } ctl_t;

    ctl_t     ctl_d, ctl_q;
    swc_cfg_t cfg;
    logic     wake_edge;
    logic     stab_ovf;

    swc_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_allow(ctl_q.st == ST_RUN),
        .wr_data (swc_cfg_t'(cfg_wdata)),
        .cfg     (cfg)
    );

    swc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (nmi_pin),
        .sel_rise (cfg.wake_rise),
        .wake_edge(wake_edge)
    );

    swc_stab_wdt #(.CODE_W(CODE_W)) u_wdt (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (ctl_q.st == ST_STABILIZE),
        .code (cfg.code),
        .ovf  (stab_ovf)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (!man_rst_n) begin
            ctl_d.st = ST_RUN;
        end else begin
            unique case (ctl_q.st)
                ST_RUN:       if (standby_req) ctl_d.st = ST_STANDBY;
                ST_STANDBY:   if (wake_edge)   ctl_d.st = ST_STABILIZE;
                ST_STABILIZE: if (stab_ovf)    ctl_d.st = ST_WAKE;
                ST_WAKE:                       ctl_d.st = ST_RUN;
                default:                       ctl_d.st = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q.st <= ST_RUN;
        else        ctl_q    <= ctl_d;
    end

    assign osc_en      = (ctl_q.st != ST_STANDBY);
    assign wdt_clk_en  = (ctl_q.st != ST_STANDBY);
    assign chip_clk_en = (ctl_q.st == ST_RUN) || (ctl_q.st == ST_WAKE);
    assign nmi_exc_req = (ctl_q.st == ST_WAKE);

    assert_enter_standby_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_RUN && standby_req && man_rst_n) |=> (!osc_en && !chip_clk_en));

    assert_stay_asleep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_STANDBY && !wake_edge && man_rst_n) |=> !osc_en);

    assert_exc_after_stab_R6: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_exc_req |-> $past(ctl_q.st == ST_STABILIZE));

    assert_exc_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_exc_req |=> !nmi_exc_req);

    assert_man_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !man_rst_n |=> (chip_clk_en && !nmi_exc_req));

endmodule

// File: tb/tb_standby_wake_ctrl.sv
module tb_standby_wake_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       man_rst_n = 1'b1;
    logic       standby_req = 1'b0;
    logic       nmi_pin = 1'b1;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_wdata = '0;
    logic       osc_en, wdt_clk_en, chip_clk_en, nmi_exc_req;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    standby_wake_ctrl dut (
        .clk(clk), .rst_n(rst_n), .man_rst_n(man_rst_n), .standby_req(standby_req),
        .nmi_pin(nmi_pin), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .osc_en(osc_en), .wdt_clk_en(wdt_clk_en), .chip_clk_en(chip_clk_en),
        .nmi_exc_req(nmi_exc_req)
    );

    function automatic int exp_period(input int k);
        return 1 << (k + 1);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input bit rise, input int k);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = {rise, 3'(k)};
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_idle(input bit rise);
        @(negedge clk);
        nmi_pin = rise ? 1'b0 : 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic enter_standby();
        @(negedge clk);
        standby_req = 1'b1;
        @(negedge clk);
        standby_req = 1'b0;
        chk(!osc_en && !wdt_clk_en && !chip_clk_en, "R2 clocks off in standby",
            {osc_en, wdt_clk_en, chip_clk_en}, 0);
    endtask

    // counts stabilization cycles until the chip clock returns, then checks the exception pulse
    task automatic measure(input int expect_cycles, input string req);
        int stab = 0;
        bit seen = 1'b0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (chip_clk_en) begin seen = 1'b1; break; end
            if (wdt_clk_en) stab++;
        end
        chk(seen && stab == expect_cycles, req, stab, expect_cycles);
        chk(nmi_exc_req == 1'b1, "R6 exception pulse on wake", int'(nmi_exc_req), 1);
        @(negedge clk);
        chk(nmi_exc_req == 1'b0 && chip_clk_en, "R6 single pulse then run",
            int'(nmi_exc_req), 0);
    endtask

    task automatic wake(input bit rise, input int expect_cycles, input string req);
        nmi_pin = rise ? 1'b1 : 1'b0;
        measure(expect_cycles, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd4242);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(osc_en && wdt_clk_en && chip_clk_en && !nmi_exc_req, "R1 reset outputs",
            {osc_en, wdt_clk_en, chip_clk_en, nmi_exc_req}, 4'b1110);

        // R1/R5: default register gives falling edge, period 2
        set_idle(1'b0);
        enter_standby();
        wake(1'b0, exp_period(0), "R5 default code 0 period");

        // R5: longest period, rising edge
        write_cfg(1'b1, 7);
        set_idle(1'b1);
        enter_standby();
        wake(1'b1, exp_period(7), "R5 code 7 period");

        // R4 opposite edge ignored; R3 write in standby ignored
        write_cfg(1'b0, 2);
        @(negedge clk);
        nmi_pin = 1'b0;
        repeat (4) @(negedge clk);
        enter_standby();
        nmi_pin = 1'b1;
        repeat (12) @(negedge clk);
        chk(!osc_en && !chip_clk_en, "R4 opposite edge ignored", int'(osc_en), 0);
        write_cfg(1'b1, 7);
        repeat (4) @(negedge clk);
        chk(!osc_en, "R3 write in standby no wake", int'(osc_en), 0);
        wake(1'b0, exp_period(2), "R3 standby write ignored, code 2 kept");

        // R7: extra edges mid-count do not restart
        write_cfg(1'b0, 7);
        set_idle(1'b0);
        enter_standby();
        nmi_pin = 1'b0;
        fork
            begin
                repeat (40) @(negedge clk);
                nmi_pin = 1'b1;
                repeat (10) @(negedge clk);
                nmi_pin = 1'b0;
            end
        join_none
        measure(exp_period(7), "R7 extra edges ignored");

        // R8: manual reset during stabilization
        write_cfg(1'b0, 5);
        set_idle(1'b0);
        enter_standby();
        nmi_pin = 1'b0;
        repeat (20) @(negedge clk);
        chk(osc_en && !chip_clk_en, "R5 stabilizing before manual reset", int'(chip_clk_en), 0);
        man_rst_n = 1'b0;
        @(negedge clk);
        man_rst_n = 1'b1;
        chk(chip_clk_en && !nmi_exc_req, "R8 manual reset in stabilize",
            {chip_clk_en, nmi_exc_req}, 2'b10);
        @(negedge clk);
        chk(chip_clk_en && !nmi_exc_req, "R8 no exception after manual reset",
            int'(nmi_exc_req), 0);

        // R8: manual reset in standby, with a standby request also present
        set_idle(1'b0);
        enter_standby();
        man_rst_n = 1'b0;
        @(negedge clk);
        man_rst_n = 1'b1;
        chk(osc_en && chip_clk_en && !nmi_exc_req, "R8 manual reset in standby",
            int'(chip_clk_en), 1);
        @(negedge clk);
        man_rst_n = 1'b0;
        standby_req = 1'b1;
        @(negedge clk);
        man_rst_n = 1'b1;
        standby_req = 1'b0;
        chk(chip_clk_en, "R8 manual reset beats standby request", int'(chip_clk_en), 1);

        // R9: asynchronous power-on reset in standby
        write_cfg(1'b1, 6);
        set_idle(1'b1);
        enter_standby();
        rst_n = 1'b0;
        #1;
        chk(osc_en && chip_clk_en && !nmi_exc_req, "R9 async reset wakes",
            {osc_en, chip_clk_en}, 2'b11);
        @(negedge clk);
        rst_n = 1'b1;
        set_idle(1'b0);
        enter_standby();
        wake(1'b0, exp_period(0), "R9 register defaults restored");

        // random sweep
        for (int n = 0; n < 16; n++) begin
            bit rise_r;
            int k_r;
            int gap_r;
            rise_r = 1'($urandom % 2);
            k_r = int'($urandom % 8);
            gap_r = int'($urandom % 16);
            write_cfg(rise_r, k_r);
            set_idle(rise_r);
            enter_standby();
            repeat (gap_r) @(negedge clk);
            chk(!osc_en, "R2 stays off until wake", int'(osc_en), 0);
            wake(rise_r, exp_period(k_r), "R5 random code period");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule